// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges five interrupt sources into a single request line toward a processor core and, when the core acknowledges, reports which source won and which restart address the core should branch to. One source is a non-maskable trap. Three are restart lines, each with its own mask bit; the highest of these is edge-latched and the other two follow their input level. The fifth is a general request whose opcode is supplied elsewhere. The fixed priority from highest to lowest is trap, high restart, middle restart, low restart, then general request.

A global interrupt enable gates every source except the trap. The core sets it with an enable command and clears it with a disable command. Accepting any maskable source also clears it, and it stays clear until software enables it again. The trap vector and the three restart vectors sit in the middle of 8-byte restart slots, so each handler entry has only four bytes before the next slot begins. A status port shows the mask bits, the global enable and the raw pending state of the three restart lines.

The control is a three-state machine. ST_IDLE means nothing is eligible. ST_PEND means a request is offered to the core. ST_GRANT is the single cycle in which a grant is presented. The transitions are: idle-to-pend when any source becomes eligible; pend-to-grant on acknowledge; pend-to-idle when eligibility disappears before acknowledge; and grant-to-pend or grant-to-idle, depending on whether anything is still eligible.

Top module: `vec_intc`

## Requirements
- R1: After reset: irq_o is 0, grant_o is 0, vec_o is 0, all three mask bits are 1, the global enable is 0 and no restart source is pending (status_o = 7'h07).
- R2: When several eligible sources are pending at acknowledge, exactly one grant_o bit rises. Priority from highest to lowest is trap, high restart, middle restart, low restart, general request.
- R3: grant_o bit positions are 0 trap, 1 high restart, 2 middle restart, 3 low restart and 4 general request. The vectors are 24h for trap, 3Ch for high, 34h for middle and 2Ch for low. A general-request grant reports vector 0.
- R4: The trap cannot be masked or disabled. It is taken only after a rising edge, and only if the input is still high in the cycle after the edge. While the input stays high after its grant it is not taken again.
- R5: A mask write loads mask_d_i. Bit 0 masks the low restart, bit 1 the middle and bit 2 the high. A 1 blocks that source.
- R6: ie_set_i sets the global enable and ie_clr_i clears it. If both are asserted in the same cycle, the clear wins.
- R7: Granting any maskable source clears the global enable. Granting the trap leaves it unchanged. There is no in-service lock-out, so a lower source is taken while a higher source's handler runs if enables allow.
- R8: A rising edge on the high restart input is latched and stays pending after the input falls, until that source is granted. The middle and low restarts are level sensitive, so dropping the input withdraws the request.
- R9: status_o bits [2:0] are the mask bits, bit 3 is the global enable, bit 4 is the low restart input, bit 5 is the middle restart input and bit 6 is the high restart latch.
- R10: irq_o is high only in ST_PEND. An acknowledge while irq_o is high and a source is still eligible produces a one-cycle grant_o pulse in the next cycle, during which irq_o is low. vec_o holds the last granted vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable trap request |
| req_hi_i | input | 1 | High restart request, edge latched |
| req_mid_i | input | 1 | Middle restart request, level |
| req_lo_i | input | 1 | Low restart request, level |
| req_ext_i | input | 1 | General request, level |
| ie_set_i | input | 1 | Enable command |
| ie_clr_i | input | 1 | Disable command |
| mask_we_i | input | 1 | Mask write strobe |
| mask_d_i | input | 3 | Mask write data |
| ack_i | input | 1 | Core acknowledge |
| irq_o | output | 1 | Request to the core |
| grant_o | output | 5 | One-hot granted source, one-cycle pulse |
| vec_o | output | VEC_W | Vector of the last grant |
| status_o | output | 7 | Mask, enable and pending view |

## Verification
A stale global enable shows on status_o bit 3 in the cycle after a grant. It also shows as a request that is offered or withheld within two cycles of a level input changing. A lost or stuck high-restart latch shows on status_o bit 6 one cycle after the input edge, or after its grant. A wrong priority chain or vector table shows directly on grant_o and vec_o in the cycle after acknowledge. A trap latch that ignores the input level shows as an irq_o rising two cycles after a one-cycle trap pulse.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NSRC     = 5;
    localparam int IDX_TRAP = 0;
    localparam int IDX_HI   = 1;
    localparam int IDX_MID  = 2;
    localparam int IDX_LO   = 3;
    localparam int IDX_EXT  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_GRANT = 2'd2
    } state_e;

    // entry address at the middle of a restart slot
    function automatic int unsigned slot_vec(input int unsigned slot,
                                             input int unsigned bytes);
        return slot * bytes + bytes / 2;
    endfunction

endpackage

// File: rtl/vic_edge_catch.sv
module vic_edge_catch #(
    parameter bit QUAL_LEVEL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic rise;

    assign rise = sig_i & ~prev_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= sig_i;
    end

    generate
        if (QUAL_LEVEL) begin : g_qual
            // edge must still be backed by a high level to count
            logic hit_q;
            always_ff @(posedge clk_i) begin
                if (!rst_ni)                 hit_q <= 1'b0;
                else if (rise)               hit_q <= 1'b1;
                else if (clr_i || !sig_i)    hit_q <= 1'b0;
            end
            assign pend_o = hit_q & sig_i;
        end else begin : g_hold
            logic hit_q;
            always_ff @(posedge clk_i) begin
                if (!rst_ni)      hit_q <= 1'b0;
                else if (rise)    hit_q <= 1'b1;
                else if (clr_i)   hit_q <= 1'b0;
            end
            assign pend_o = hit_q;
        end
    endgenerate
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pick_o,
    output logic         any_o
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign pick_o[i]  = req_i[i] & ~seen[i];
            assign seen[i+1]  = seen[i] | req_i[i];
        end
    endgenerate

    assign any_o = seen[N];
endmodule

// File: rtl/vic_enable_ctl.sv
module vic_enable_ctl #(
    parameter int MW = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ie_set_i,
    input  logic          ie_clr_i,
    input  logic          take_mask_i,
    input  logic          mask_we_i,
    input  logic [MW-1:0] mask_d_i,
    output logic          ie_o,
    output logic [MW-1:0] mask_o
);
    logic          ie_q;
    logic [MW-1:0] mask_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                       ie_q <= 1'b0;
        else if (ie_clr_i || take_mask_i)  ie_q <= 1'b0;
        else if (ie_set_i)                 ie_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)        mask_q <= '1;
        else if (mask_we_i) mask_q <= mask_d_i;
    end

    assign ie_o   = ie_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/vec_intc.sv
module vec_intc #(
    parameter int VEC_W      = 16,
    parameter int SLOT_BYTES = 8,
    parameter int TRAP_SLOT  = 4,
    parameter int LO_SLOT    = 5,
    parameter int MID_SLOT   = 6,
    parameter int HI_SLOT    = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trap_i,
    input  logic             req_hi_i,
    input  logic             req_mid_i,
    input  logic             req_lo_i,
    input  logic             req_ext_i,
    input  logic             ie_set_i,
    input  logic             ie_clr_i,
    input  logic             mask_we_i,
    input  logic [2:0]       mask_d_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [4:0]       grant_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [6:0]       status_o
);
    import vic_pkg::*;

    localparam int MW = 3;
    localparam logic [VEC_W-1:0] VEC_TRAP = VEC_W'(slot_vec(TRAP_SLOT, SLOT_BYTES));
    localparam logic [VEC_W-1:0] VEC_HI   = VEC_W'(slot_vec(HI_SLOT,   SLOT_BYTES));
    localparam logic [VEC_W-1:0] VEC_MID  = VEC_W'(slot_vec(MID_SLOT,  SLOT_BYTES));
    localparam logic [VEC_W-1:0] VEC_LO   = VEC_W'(slot_vec(LO_SLOT,   SLOT_BYTES));
    localparam logic [VEC_W-1:0] VEC_TAB [NSRC] = '{VEC_TRAP, VEC_HI, VEC_MID, VEC_LO, '0};

    state_e            state_q, state_d;
    logic              trap_pend, hi_pend;
    logic              ie;
    logic [MW-1:0]     mask;
    logic [NSRC-1:0]   elig, pick, take_vec;
    logic              any_elig, take, take_mask;
    logic [NSRC-1:0]   grant_q;
    logic [VEC_W-1:0]  vec_q, vec_pick;

    // source capture
    vic_edge_catch #(.QUAL_LEVEL(1'b1)) u_trap (
        .clk_i (clk_i), .rst_ni (rst_ni), .sig_i (trap_i),
        .clr_i (take_vec[IDX_TRAP]), .pend_o (trap_pend)
    );

    vic_edge_catch #(.QUAL_LEVEL(1'b0)) u_hi (
        .clk_i (clk_i), .rst_ni (rst_ni), .sig_i (req_hi_i),
        .clr_i (take_vec[IDX_HI]), .pend_o (hi_pend)
    );

    vic_enable_ctl #(.MW(MW)) u_en (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ie_set_i    (ie_set_i),
        .ie_clr_i    (ie_clr_i),
        .take_mask_i (take_mask),
        .mask_we_i   (mask_we_i),
        .mask_d_i    (mask_d_i),
        .ie_o        (ie),
        .mask_o      (mask)
    );

    // eligibility in priority order
    assign elig[IDX_TRAP] = trap_pend;
    assign elig[IDX_HI]   = ie & ~mask[2] & hi_pend;
    assign elig[IDX_MID]  = ie & ~mask[1] & req_mid_i;
    assign elig[IDX_LO]   = ie & ~mask[0] & req_lo_i;
    assign elig[IDX_EXT]  = ie & req_ext_i;

    vic_prio_pick #(.N(NSRC)) u_pick (
        .req_i  (elig),
        .pick_o (pick),
        .any_o  (any_elig)
    );

    assign take      = (state_q == ST_PEND) & ack_i & any_elig;
    assign take_vec  = take ? pick : '0;
    assign take_mask = |take_vec[NSRC-1:1];

    always_comb begin
        vec_pick = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pick[i]) vec_pick = vec_pick | VEC_TAB[i];
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_elig) state_d = ST_PEND;
            ST_PEND: begin
                if (!any_elig)  state_d = ST_IDLE;
                else if (ack_i) state_d = ST_GRANT;
            end
            ST_GRANT: state_d = any_elig ? ST_PEND : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // grant and vector registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            grant_q <= '0;
            vec_q   <= '0;
        end else begin
            grant_q <= take_vec;
            if (take) vec_q <= vec_pick;
        end
    end

    // outputs
    always_comb begin
        irq_o    = (state_q == ST_PEND);
        grant_o  = grant_q;
        vec_o    = vec_q;
        status_o = {hi_pend, req_mid_i, req_lo_i, ie, mask};
    end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
    parameter int VEC_W = 16,
    parameter logic [VEC_W-1:0] TRAP_VEC = '0,
    parameter logic [VEC_W-1:0] HI_VEC   = '0
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ack_i,
    input logic             irq_o,
    input logic             trap_pend,
    input logic [4:0]       grant_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [6:0]       status_o
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o)); // R2

    AST_GRANT_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|grant_o) |-> $past(ack_i && irq_o)); // R10

    AST_IRQ_LOW_IN_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|grant_o) |-> !irq_o); // R10

    AST_TRAP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o && trap_pend) |=> grant_o[0]); // R4

    AST_MASKABLE_DROPS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|grant_o[4:1]) |-> !status_o[3]); // R7

    AST_TRAP_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o[0] |-> (vec_o == TRAP_VEC)); // R3

    AST_HI_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o[1] |-> (vec_o == HI_VEC)); // R3

    AST_LO_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o[3] |-> !$past(status_o[0])); // R5
endmodule

bind vec_intc vec_intc_chk #(
    .VEC_W    (VEC_W),
    .TRAP_VEC (VEC_TRAP),
    .HI_VEC   (VEC_HI)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .trap_pend (trap_pend),
    .grant_o   (grant_o),
    .vec_o     (vec_o),
    .status_o  (status_o)
);

// File: tb/vec_intc_tb_top.sv
module vec_intc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 16;

    // {enable, mask[2:0], req{ext,lo,mid,hi,trap}, grant[4:0], vec[7:0]}
    localparam logic [21:0] TBL [10] = '{
        {1'b1, 3'b000, 5'b11111, 5'b00001, 8'h24},
        {1'b1, 3'b000, 5'b11110, 5'b00010, 8'h3C},
        {1'b1, 3'b000, 5'b11100, 5'b00100, 8'h34},
        {1'b1, 3'b000, 5'b11000, 5'b01000, 8'h2C},
        {1'b1, 3'b000, 5'b10000, 5'b10000, 8'h00},
        {1'b1, 3'b100, 5'b01110, 5'b00100, 8'h34},
        {1'b1, 3'b110, 5'b01110, 5'b01000, 8'h2C},
        {1'b1, 3'b111, 5'b11110, 5'b10000, 8'h00},
        {1'b0, 3'b111, 5'b00001, 5'b00001, 8'h24},
        {1'b0, 3'b000, 5'b10110, 5'b00000, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap = 1'b0, r_hi = 1'b0, r_mid = 1'b0, r_lo = 1'b0, r_ext = 1'b0;
    logic ie_set = 1'b0, ie_clr = 1'b0, mask_we = 1'b0, ack = 1'b0;
    logic [2:0] mask_d = 3'b000;
    logic irq;
    logic [4:0] grant;
    logic [VW-1:0] vec;
    logic [6:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_intc #(.VEC_W(VW)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .trap_i (trap), .req_hi_i (r_hi),
        .req_mid_i (r_mid), .req_lo_i (r_lo), .req_ext_i (r_ext),
        .ie_set_i (ie_set), .ie_clr_i (ie_clr), .mask_we_i (mask_we),
        .mask_d_i (mask_d), .ack_i (ack), .irq_o (irq), .grant_o (grant),
        .vec_o (vec), .status_o (status)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        {trap, r_hi, r_mid, r_lo, r_ext} = '0;
        {ie_set, ie_clr, mask_we, ack} = '0;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wr_mask(input logic [2:0] m);
        mask_we = 1'b1; mask_d = m;
        tick(1);
        mask_we = 1'b0;
    endtask

    task automatic en_pulse();
        ie_set = 1'b1;
        tick(1);
        ie_set = 1'b0;
    endtask

    task automatic do_ack(input string req, input logic [4:0] eg, input logic [7:0] ev);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        chk(req, "grant", grant, eg);
        chk(req, "vec", vec, ev);
        chk(req, "irq in grant cycle", irq, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(1);
        do_reset();
        // R1 reset state
        chk("R1", "irq", irq, 1'b0);
        chk("R1", "grant", grant, 5'b0);
        chk("R1", "vec", vec, '0);
        chk("R1", "status", status, 7'h07);

        // R2 R3 R5 priority table
        for (int i = 0; i < 10; i++) begin
            do_reset();
            wr_mask(TBL[i][20:18]);
            if (TBL[i][21]) en_pulse();
            {r_ext, r_lo, r_mid, r_hi, trap} = TBL[i][17:13];
            tick(3);
            chk("R2", "irq offered", irq, |TBL[i][12:8]);
            if (|TBL[i][12:8]) do_ack("R2 R3", TBL[i][12:8], TBL[i][7:0]);
            {r_ext, r_lo, r_mid, r_hi, trap} = '0;
            tick(2);
        end

        // R6 enable and disable commands
        do_reset();
        ie_set = 1'b1; ie_clr = 1'b1;
        tick(1);
        ie_set = 1'b0; ie_clr = 1'b0;
        chk("R6", "clear wins", status[3], 1'b0);
        en_pulse();
        chk("R6", "set", status[3], 1'b1);
        ie_clr = 1'b1;
        tick(1);
        ie_clr = 1'b0;
        chk("R6", "clear", status[3], 1'b0);

        // R8 R9 high restart latch survives input drop
        do_reset();
        wr_mask(3'b000);
        r_hi = 1'b1;
        tick(1);
        r_hi = 1'b0;
        tick(1);
        chk("R8", "hi latched", status[6], 1'b1);
        chk("R9", "mask field", status[2:0], 3'b000);
        chk("R8", "no irq while disabled", irq, 1'b0);
        en_pulse();
        tick(2);
        chk("R8", "irq from latch", irq, 1'b1);
        do_ack("R8", 5'b00010, 8'h3C);
        chk("R8", "latch cleared", status[6], 1'b0);
        chk("R7", "ie cleared by maskable", status[3], 1'b0);

        // R8 level source withdrawn
        do_reset();
        wr_mask(3'b000);
        en_pulse();
        r_mid = 1'b1;
        tick(3);
        chk("R8", "mid irq", irq, 1'b1);
        chk("R9", "mid pending bit", status[5], 1'b1);
        r_mid = 1'b0;
        tick(2);
        chk("R8", "mid withdrawn", irq, 1'b0);

        // R4 short trap pulse not taken
        do_reset();
        trap = 1'b1;
        tick(1);
        trap = 1'b0;
        tick(3);
        chk("R4", "short trap ignored", irq, 1'b0);

        // R4 R7 held trap, no retrigger, no lock-out
        do_reset();
        wr_mask(3'b000);
        en_pulse();
        trap = 1'b1;
        tick(3);
        chk("R4", "trap irq", irq, 1'b1);
        do_ack("R4", 5'b00001, 8'h24);
        chk("R7", "trap keeps ie", status[3], 1'b1);
        tick(2);
        chk("R4", "held trap no retrigger", irq, 1'b0);
        r_lo = 1'b1;
        tick(3);
        chk("R7", "lower taken during trap", irq, 1'b1);
        do_ack("R7", 5'b01000, 8'h2C);
        trap = 1'b0; r_lo = 1'b0;

        // R5 mask write gates low restart
        do_reset();
        en_pulse();
        r_lo = 1'b1;
        tick(3);
        chk("R5", "masked low blocked", irq, 1'b0);
        wr_mask(3'b110);
        tick(3);
        chk("R5", "unmasked low offered", irq, 1'b1);
        chk("R9", "mask readback", status[2:0], 3'b110);
        r_lo = 1'b0;
        tick(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule